// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static RAM Model

This block is a cycle-level, synthesizable stand-in for a 16-bit asynchronous static RAM with separate lower and upper byte lanes. It serves as a target for controllers under test. All of its control inputs are active low: a chip enable, a write enable, an output enable and one select per byte lane. The bidirectional data bus is split into a data-in word, a data-out word and a per-lane drive enable, so a parent can build the tri-state pins from them.

A write is in progress while both chip enable and write enable are low. The write ends when either of them rises. On the clock edge where the write condition drops, the model stores the data-in word into the lanes that were selected during the write. The address pins are 18 bits wide. A parameter sets how many of the low address bits index the array, so a simulation can use a small array; the upper address bits then alias. An error flag goes high when the address moves during a write that was already active on the previous clock edge.

Top module: `sram16_model`

## Requirements
- R1: While chip enable is high, both lanes are undriven (lane_oe = 2'b00) and dout reads 0, whatever the other inputs are.
- R2: With chip enable low, write enable high and output enable high, both lanes are undriven.
- R3: With both lane selects high, no lane is driven and a write changes no stored byte.
- R4: A read (chip enable low, write enable high, output enable low) drives only the lanes whose select is low. lane_oe[0] and dout[7:0] belong to the lower lane (lb_n), and lane_oe[1] and dout[15:8] belong to the upper lane (ub_n). An undriven lane reads as 0 on dout.
- R5: During a write (chip enable low and write enable low), no lane is driven, whatever output enable is set to. Only the lanes whose select is low are stored.
- R6: The write is committed on the clock edge where the write condition goes from active to inactive. Either write enable rising or chip enable rising ends it. The byte data is the din present at that edge, and it can be read back in the next cycle.
- R7: Only the low ADDR_W address bits select a word (default 8). Addresses that differ only above that width refer to the same word.
- R8: addr_err is high while a write that was active on the previous clock edge is still active and the address differs from the one sampled at that edge. The write is stored at the address sampled on the last edge before it ended.
- R9: Reset clears any write in progress. A write condition that ends while reset is asserted or just after it stores nothing, and addr_err is 0 under reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 18 | Word address |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| lb_n | input | 1 | Lower byte lane select, active low |
| ub_n | input | 1 | Upper byte lane select, active low |
| din | input | 16 | Write data from the bus |
| dout | output | 16 | Read data, 0 on undriven lanes |
| lane_oe | output | 2 | Per-lane drive enable, bit 0 lower, bit 1 upper |
| addr_err | output | 1 | Address moved during an active write |

## Verification
The hardest states to reach from the ports are a write that ends inside reset and an address that moves in the middle of a write. Both depend on where the control edges fall relative to clock edges, not only on the values on the pins. The bench drives every input on the falling clock edge. This lets it place the start of a write, an address change and the end of the write on chosen rising edges one after another. It then asserts reset between the start and the end of a write, and reads the word back afterwards to prove that nothing was stored.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  // Active-low selects {ub_n, lb_n} to an active-high lane mask.
  function automatic logic [LANES-1:0] lane_mask(input logic ub_n, input logic lb_n);
    return ~{ub_n, lb_n};
  endfunction

  // Replicate each mask bit across its byte.
  function automatic logic [WORD_W-1:0] byte_spread(input logic [LANES-1:0] m);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*LANE_W +: LANE_W] = {LANE_W{m[i]}};
    return r;
  endfunction
endpackage

// File: rtl/sram_ctrl_decode.sv
module sram_ctrl_decode
  import sram_pkg::*;
(
  input  logic             ce_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic             lb_n,
  input  logic             ub_n,
  output logic             wr_active,
  output logic [LANES-1:0] sel_mask,
  output logic [LANES-1:0] drive
);
  logic rd_active;

  always_comb begin
    sel_mask  = lane_mask(ub_n, lb_n);
    wr_active = !ce_n && !we_n;
    rd_active = !ce_n && we_n && !oe_n;
    drive     = rd_active ? sel_mask : '0;
  end
endmodule

// File: rtl/sram_write_track.sv
module sram_write_track
  import sram_pkg::*;
#(
  parameter int PIN_AW = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_active,
  input  logic [PIN_AW-1:0] addr,
  input  logic [LANES-1:0]  sel_mask,
  output logic              wr_commit,
  output logic [PIN_AW-1:0] wr_addr,
  output logic [LANES-1:0]  wr_mask,
  output logic              addr_err
);
  logic wr_active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_active_q <= 1'b0;
      wr_addr     <= '0;
      wr_mask     <= '0;
    end else begin
      wr_active_q <= wr_active;
      if (wr_active) begin
        wr_addr <= addr;
        wr_mask <= sel_mask;
      end
    end
  end

  assign wr_commit = wr_active_q && !wr_active;
  assign addr_err  = wr_active_q && wr_active && (addr != wr_addr);
endmodule

// File: rtl/sram_byte_lane.sv
module sram_byte_lane
  import sram_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LANE_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LANE_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;
  logic [LANE_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_idx] <= wr_data;
  end

  assign rd_data = cells[rd_idx];
endmodule

// File: rtl/sram16_model.sv
module sram16_model
  import sram_pkg::*;
#(
  parameter int PIN_AW = 18,
  parameter int ADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PIN_AW-1:0]  addr,
  input  logic               ce_n,
  input  logic               we_n,
  input  logic               oe_n,
  input  logic               lb_n,
  input  logic               ub_n,
  input  logic [WORD_W-1:0]  din,
  output logic [WORD_W-1:0]  dout,
  output logic [LANES-1:0]   lane_oe,
  output logic               addr_err
);
  logic              wr_active;
  logic              wr_commit;
  logic [LANES-1:0]  sel_mask;
  logic [LANES-1:0]  drive;
  logic [PIN_AW-1:0] wr_addr;
  logic [LANES-1:0]  wr_mask;
  logic [WORD_W-1:0] rd_word;

  sram_ctrl_decode u_dec (
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .lb_n(lb_n), .ub_n(ub_n),
    .wr_active(wr_active), .sel_mask(sel_mask), .drive(drive)
  );

  sram_write_track #(.PIN_AW(PIN_AW)) u_trk (
    .clk(clk), .rst_n(rst_n), .wr_active(wr_active), .addr(addr),
    .sel_mask(sel_mask), .wr_commit(wr_commit), .wr_addr(wr_addr),
    .wr_mask(wr_mask), .addr_err(addr_err)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_byte_lane #(.IDX_W(ADDR_W)) u_lane (
      .clk(clk),
      .wr_en(wr_commit && wr_mask[g]),
      .wr_idx(wr_addr[ADDR_W-1:0]),
      .wr_data(din[g*LANE_W +: LANE_W]),
      .rd_idx(addr[ADDR_W-1:0]),
      .rd_data(rd_word[g*LANE_W +: LANE_W])
    );
  end

  assign lane_oe = drive;
  assign dout    = rd_word & byte_spread(drive);
endmodule

// File: rtl/sram16_model_chk.sv
module sram16_model_chk
  import sram_pkg::*;
#(
  parameter int PIN_AW = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PIN_AW-1:0] addr,
  input logic              ce_n,
  input logic              we_n,
  input logic              oe_n,
  input logic              lb_n,
  input logic              ub_n,
  input logic [WORD_W-1:0] dout,
  input logic [LANES-1:0]  lane_oe,
  input logic              addr_err,
  input logic              wr_active,
  input logic              wr_commit
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  // R1
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (lane_oe == '0 && dout == '0));
  // R2
  oe_high_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && we_n && oe_n) |-> lane_oe == '0);
  // R4
  read_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && we_n && !oe_n) |-> lane_oe == ~{ub_n, lb_n});
  // R4
  idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_oe[0] |-> dout[7:0] == 8'h00);
  // R4
  idle_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_oe[1] |-> dout[15:8] == 8'h00);
  // R5
  write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !we_n) |-> lane_oe == '0);
  // R6
  commit_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && wr_commit) |-> ($past(wr_active) && !wr_active));
  // R8
  addr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && wr_active && $past(wr_active) && addr != $past(addr)) |-> addr_err);
  // R8
  addr_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> (!ce_n && !we_n));
endmodule

bind sram16_model sram16_model_chk #(.PIN_AW(PIN_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .we_n(we_n),
  .oe_n(oe_n), .lb_n(lb_n), .ub_n(ub_n), .dout(dout), .lane_oe(lane_oe),
  .addr_err(addr_err), .wr_active(wr_active), .wr_commit(wr_commit)
);

// File: tb/tb_sram16_model.sv
module tb_sram16_model;
  localparam int AW = 8;
  localparam int NV = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] addr = '0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic [1:0]  lane_oe;
  logic        addr_err;

  int checks = 0;
  int errors = 0;
  logic [15:0] shadow [1 << AW];

  sram16_model #(.PIN_AW(18), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .lb_n(lb_n), .ub_n(ub_n), .din(din), .dout(dout),
    .lane_oe(lane_oe), .addr_err(addr_err)
  );

  always #10 clk = ~clk;

  // op 0 = write, 1 = read; sel = {ub_n, lb_n}
  localparam logic        T_OP   [NV] = '{0, 0, 1, 0, 1, 0, 1, 1, 0, 1, 0, 1};
  localparam logic [17:0] T_ADDR [NV] = '{18'h00010, 18'h00011, 18'h00010, 18'h00010,
                                          18'h00010, 18'h00011, 18'h00011, 18'h00011,
                                          18'h00010, 18'h00010, 18'h3FF12, 18'h00012};
  localparam logic [1:0]  T_SEL  [NV] = '{2'b00, 2'b00, 2'b00, 2'b10, 2'b00, 2'b01,
                                          2'b10, 2'b01, 2'b11, 2'b00, 2'b00, 2'b00};
  localparam logic [15:0] T_DATA [NV] = '{16'hA5C3, 16'h1234, 16'h0000, 16'h00EE,
                                          16'h0000, 16'h7700, 16'h0000, 16'h0000,
                                          16'hFFFF, 16'h0000, 16'hBEEF, 16'h0000};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [17:0] a, input logic [1:0] sel, input logic [15:0] d,
                          input logic oe, input logic end_by_ce);
    @(negedge clk);
    addr = a; {ub_n, lb_n} = sel; oe_n = oe; ce_n = 1'b0; we_n = 1'b0; din = ~d;
    #2 check("R5 no drive during write", {30'd0, lane_oe}, 32'd0);
    @(negedge clk);
    din = d;
    if (end_by_ce) ce_n = 1'b1; else we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    if (!sel[0]) shadow[a[AW-1:0]][7:0]  = d[7:0];
    if (!sel[1]) shadow[a[AW-1:0]][15:8] = d[15:8];
  endtask

  task automatic do_read(input string req, input logic [17:0] a, input logic [1:0] sel);
    logic [1:0]  lanes;
    logic [15:0] exp;
    lanes = ~sel;
    exp = shadow[a[AW-1:0]] & {{8{lanes[1]}}, {8{lanes[0]}}};
    @(negedge clk);
    addr = a; {ub_n, lb_n} = sel; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
    #2;
    check({req, " data"}, {16'd0, dout}, {16'd0, exp});
    check({req, " lanes"}, {30'd0, lane_oe}, {30'd0, lanes});
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk);
    check("R9 reset lanes", {30'd0, lane_oe}, 32'd0);
    check("R9 reset addr_err", {31'd0, addr_err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table: R3, R4, R5, R6, R7
    for (int i = 0; i < NV; i++) begin
      if (T_OP[i] == 1'b0) do_write(T_ADDR[i], T_SEL[i], T_DATA[i], i[0], 1'b0);
      else do_read($sformatf("R4/R7 vec%0d", i), T_ADDR[i], T_SEL[i]);
    end
    check("R3 both selects leave word", {16'd0, shadow[8'h10]}, 32'h0000A5EE);
    check("R7 alias stored", {16'd0, shadow[8'h12]}, 32'h0000BEEF);

    // R1 deselected read stays quiet
    @(negedge clk);
    addr = 18'h10; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b0; {ub_n, lb_n} = 2'b00;
    #2 check("R1 deselect lanes", {30'd0, lane_oe}, 32'd0);
    check("R1 deselect data", {16'd0, dout}, 32'd0);
    // R2 output enable high
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b1;
    #2 check("R2 oe high lanes", {30'd0, lane_oe}, 32'd0);
    @(negedge clk);
    ce_n = 1'b1;

    // R6 write ended by chip enable rising
    do_write(18'h20, 2'b00, 16'h1111, 1'b0, 1'b1);
    do_read("R6 ce-ended write", 18'h20, 2'b00);

    // R8 address moves during a write
    @(negedge clk);
    addr = 18'h30; {ub_n, lb_n} = 2'b00; ce_n = 1'b0; we_n = 1'b0; din = 16'h0;
    @(negedge clk);
    check("R8 stable address", {31'd0, addr_err}, 32'd0);
    addr = 18'h31;
    #2 check("R8 moved address", {31'd0, addr_err}, 32'd1);
    @(negedge clk);
    din = 16'h4321; we_n = 1'b1;
    #2 check("R8 cleared after end", {31'd0, addr_err}, 32'd0);
    @(negedge clk);
    ce_n = 1'b1;
    shadow[8'h31] = 16'h4321;
    do_read("R8 lands at last address", 18'h31, 2'b00);

    // R9 write cut by reset stores nothing
    @(negedge clk);
    addr = 18'h20; {ub_n, lb_n} = 2'b00; ce_n = 1'b0; we_n = 1'b0; din = 16'hDEAD;
    @(negedge clk);
    rst_n = 1'b0;
    #2 check("R9 addr_err in reset", {31'd0, addr_err}, 32'd0);
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1; ce_n = 1'b1;
    do_read("R9 aborted write", 18'h20, 2'b00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule